// File: doc/BRIEF.md
# Cross-Domain Indirect Register Bridge

The bridge gives a processor bus, clocked by a fast interface clock, access to a bank of registers that live in a slow, always-on clock domain. Software never addresses the far registers directly. It loads a direction code, a target address and (for writes) a data word into a small window of local registers, then sets a launch bit. One transfer crosses into the slow domain, runs there, and its completion crosses back. The launch bit reads as one for the whole flight and falls to zero once the result is in place.

The two domains share no clock and each has its own active-low reset. Launch and completion travel as level toggles through two-flop synchronisers. The window fields stay frozen while a transfer is outstanding, so the slow side can sample them without a separate data crossing. A word register file in the slow domain plays the part of the far-side peripherals. The intended software sequence is: wait for idle, program the fields, launch, and wait for idle again.

Top module: `xdom_reg_bridge`

## Requirements
- R1: After reset, all four window registers read zero and no transfer is in flight.
- R2: Window decode uses byte offsets on a 4-bit bus address: 0x0 launch/status, 0x4 direction code (8 bits), 0x8 target byte address (TGT_AW bits, read back zero-extended), 0xC data word. An access whose two low address bits are not zero reaches no register and reads zero.
- R3: A write to offset 0x0 with bit 0 set, while idle, launches one transfer; offset 0x0 then reads 1 from the next cycle until completion and 0 afterwards. A write there with bit 0 clear has no effect.
- R4: With direction code 0x00 the transfer is a read: after completion the data register holds the target word at word index addr[TGT_AW-1:2].
- R5: With direction code 0xF1 the transfer is a write: the target word takes the data register value, and the data register keeps that value.
- R6: Any other direction code completes normally but touches neither the target word nor the data register.
- R7: A launch write while a transfer is in flight is ignored; status stays 1 and only the first transfer takes place.
- R8: Writes to the direction, address and data registers while a transfer is in flight are ignored.
- R9: Status returns to 0 no later than four slow-clock periods plus six interface-clock cycles after the launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuClk | input | 1 | Fast interface clock |
| cpuRstN | input | 1 | Active-low reset of the interface domain |
| busValid | input | 1 | Bus access request, one cycle per access |
| busWrite | input | 1 | 1 for a write access, 0 for a read |
| busAddr | input | 4 | Byte offset into the window |
| busWdata | input | 32 | Write data |
| busReady | output | 1 | Access accepted; always 1 |
| busRdata | output | 32 | Read data, valid in the cycle of the read access |
| slowClk | input | 1 | Slow always-on clock |
| slowRstN | input | 1 | Active-low reset of the slow domain |

## Verification
A stuck or misaligned handshake toggle shows at the status port as a flag that never falls, caught by a bounded poll within about sixty interface cycles, or as one that falls before the far access ran, caught when a read-back of the same word returns the old value. Fields that move while a transfer is in flight land at the wrong target word and surface on the next read of either word. A bad direction decode shows as a changed word or a changed data register right after a no-op transfer. Random mixes of reads and writes, run against a word-array model at a clock ratio above ten to one, expose stale read data within one transfer.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
  localparam logic [1:0] OFF_CTRL = 2'd0;
  localparam logic [1:0] OFF_DIR  = 2'd1;
  localparam logic [1:0] OFF_ADDR = 2'd2;
  localparam logic [1:0] OFF_DATA = 2'd3;

  localparam logic [7:0] DIR_READ  = 8'h00;
  localparam logic [7:0] DIR_WRITE = 8'hF1;

  // strobes from the control FSM to the window datapath
  typedef struct packed {
    logic launch;
    logic ldDir;
    logic ldAddr;
    logic ldData;
    logic ldRsp;
  } strobe_t;
endpackage

// File: rtl/xbr_cpu_ctrl.sv
module xbr_cpu_ctrl
  import xbr_pkg::*;
(
  input  logic       cpuClk,
  input  logic       cpuRstN,
  input  logic       busValid,
  input  logic       busWrite,
  input  logic [3:0] busAddr,
  input  logic       startBit,
  input  logic       ackTgl,
  output strobe_t    stb,
  output logic       reqTgl,
  output logic       busyQ
);
  logic ackMeta, ackSync;
  logic wrHit;
  logic [1:0] off;

  assign off   = busAddr[3:2];
  assign wrHit = busValid && busWrite && (busAddr[1:0] == 2'b00);

  always_ff @(posedge cpuClk or negedge cpuRstN) begin
    if (!cpuRstN) begin
      ackMeta <= 1'b0;
      ackSync <= 1'b0;
    end else begin
      ackMeta <= ackTgl;
      ackSync <= ackMeta;
    end
  end

  always_comb begin
    stb        = '0;
    stb.launch = wrHit && !busyQ && (off == OFF_CTRL) && startBit;
    stb.ldDir  = wrHit && !busyQ && (off == OFF_DIR);
    stb.ldAddr = wrHit && !busyQ && (off == OFF_ADDR);
    stb.ldData = wrHit && !busyQ && (off == OFF_DATA);
    stb.ldRsp  = busyQ && (ackSync == reqTgl);
  end

  always_ff @(posedge cpuClk or negedge cpuRstN) begin
    if (!cpuRstN) begin
      reqTgl <= 1'b0;
      busyQ  <= 1'b0;
    end else if (stb.launch) begin
      reqTgl <= ~reqTgl;
      busyQ  <= 1'b1;
    end else if (stb.ldRsp) begin
      busyQ  <= 1'b0;
    end
  end
endmodule

// File: rtl/xbr_cpu_dpath.sv
module xbr_cpu_dpath
  import xbr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIR_W  = 8,
  parameter int TGT_AW = 8
) (
  input  logic              cpuClk,
  input  logic              cpuRstN,
  input  strobe_t           stb,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [3:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busyQ,
  input  logic [DATA_W-1:0] rspData,
  output logic [DIR_W-1:0]  dirQ,
  output logic [TGT_AW-1:0] addrQ,
  output logic [DATA_W-1:0] dataQ,
  output logic [DATA_W-1:0] busRdata
);
  always_ff @(posedge cpuClk or negedge cpuRstN) begin
    if (!cpuRstN) begin
      dirQ  <= '0;
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (stb.ldDir)  dirQ  <= busWdata[DIR_W-1:0];
      if (stb.ldAddr) addrQ <= busWdata[TGT_AW-1:0];
      if (stb.ldData) dataQ <= busWdata;
      else if (stb.ldRsp && dirQ == DIR_READ) dataQ <= rspData;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busValid && !busWrite && busAddr[1:0] == 2'b00) begin
      case (busAddr[3:2])
        OFF_CTRL: busRdata = {{(DATA_W-1){1'b0}}, busyQ};
        OFF_DIR:  busRdata = {{(DATA_W-DIR_W){1'b0}}, dirQ};
        OFF_ADDR: busRdata = {{(DATA_W-TGT_AW){1'b0}}, addrQ};
        default:  busRdata = dataQ;
      endcase
    end
  end
endmodule

// File: rtl/xbr_slow_target.sv
module xbr_slow_target
  import xbr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIR_W  = 8,
  parameter int IDX_W  = 6
) (
  input  logic              slowClk,
  input  logic              slowRstN,
  input  logic              reqTgl,
  input  logic [DIR_W-1:0]  dirQ,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] dataQ,
  output logic              ackTgl,
  output logic [DATA_W-1:0] rspData
);
  localparam int DEPTH = 1 << IDX_W;

  logic reqMeta, reqSync;
  logic [DATA_W-1:0] regs [DEPTH];
  logic newReq;

  assign newReq = (reqSync != ackTgl);

  always_ff @(posedge slowClk or negedge slowRstN) begin
    if (!slowRstN) begin
      reqMeta <= 1'b0;
      reqSync <= 1'b0;
      ackTgl  <= 1'b0;
      rspData <= '0;
    end else begin
      reqMeta <= reqTgl;
      reqSync <= reqMeta;
      if (newReq) begin
        ackTgl <= reqSync;
        if (dirQ == DIR_READ) rspData <= regs[wordIdx];
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge slowClk or negedge slowRstN) begin
      if (!slowRstN) regs[i] <= '0;
      else if (newReq && dirQ == DIR_WRITE && wordIdx == IDX_W'(i)) regs[i] <= dataQ;
    end
  end
endmodule

// File: rtl/xdom_reg_bridge.sv
module xdom_reg_bridge
  import xbr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIR_W  = 8,
  parameter int TGT_AW = 8
) (
  input  logic              cpuClk,
  input  logic              cpuRstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [3:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic              busReady,
  output logic [DATA_W-1:0] busRdata,
  input  logic              slowClk,
  input  logic              slowRstN
);
  localparam int IDX_W = TGT_AW - 2;

  strobe_t           stb;
  logic              reqTgl, ackTgl, busyQ;
  logic [DIR_W-1:0]  dirQ;
  logic [TGT_AW-1:0] addrQ;
  logic [DATA_W-1:0] dataQ, rspData;

  assign busReady = 1'b1;

  xbr_cpu_ctrl u_ctrl (
    .cpuClk, .cpuRstN, .busValid, .busWrite, .busAddr,
    .startBit(busWdata[0]), .ackTgl, .stb, .reqTgl, .busyQ
  );

  xbr_cpu_dpath #(.DATA_W(DATA_W), .DIR_W(DIR_W), .TGT_AW(TGT_AW)) u_dpath (
    .cpuClk, .cpuRstN, .stb, .busValid, .busWrite, .busAddr, .busWdata,
    .busyQ, .rspData, .dirQ, .addrQ, .dataQ, .busRdata
  );

  xbr_slow_target #(.DATA_W(DATA_W), .DIR_W(DIR_W), .IDX_W(IDX_W)) u_slow (
    .slowClk, .slowRstN, .reqTgl, .dirQ, .wordIdx(addrQ[TGT_AW-1:2]),
    .dataQ, .ackTgl, .rspData
  );
endmodule

// File: rtl/xbr_checker.sv
module xbr_checker #(
  parameter int DATA_W = 32,
  parameter int DIR_W  = 8,
  parameter int TGT_AW = 8
) (
  input logic              cpuClk,
  input logic              cpuRstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [3:0]        busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              reqTgl,
  input logic              busyQ,
  input logic [DIR_W-1:0]  dirQ,
  input logic [TGT_AW-1:0] addrQ,
  input logic [DATA_W-1:0] dataQ
);
  logic startWr;
  assign startWr = busValid && busWrite && busAddr == 4'h0 && busWdata[0];

  AST_LAUNCH_SETS_BUSY: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    (startWr && !busyQ) |=> busyQ); // R3
  AST_STATUS_READ: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    (busValid && !busWrite && busAddr == 4'h0) |-> busRdata == {{(DATA_W-1){1'b0}}, busyQ}); // R3
  AST_BUSY_START_IGNORED: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    (startWr && busyQ) |=> $stable(reqTgl)); // R7
  AST_FIELDS_FROZEN: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    (busyQ && $past(busyQ)) |-> ($stable(dirQ) && $stable(addrQ) && $stable(dataQ))); // R8
  AST_REQ_ONLY_FROM_IDLE: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    !$stable(reqTgl) |-> ($past(!busyQ) && busyQ)); // R7
endmodule

bind xdom_reg_bridge xbr_checker #(.DATA_W(DATA_W), .DIR_W(DIR_W), .TGT_AW(TGT_AW)) u_chk (
  .cpuClk(cpuClk), .cpuRstN(cpuRstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .reqTgl(reqTgl),
  .busyQ(busyQ), .dirQ(dirQ), .addrQ(addrQ), .dataQ(dataQ)
);

// File: tb/tb_xdom_reg_bridge.sv
module tb_xdom_reg_bridge;
  localparam int CPU_PERIOD  = 10;
  localparam int SLOW_PERIOD = 133;
  localparam int MAX_POLL    = (4 * SLOW_PERIOD) / CPU_PERIOD + 6;
  localparam int WORDS       = 64;

  logic        cpuClk = 1'b0, slowClk = 1'b0;
  logic        cpuRstN = 1'b0, slowRstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busReady;
  logic [31:0] busRdata;

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  logic [31:0] model [WORDS];

  always #(CPU_PERIOD/2) cpuClk = ~cpuClk;
  always #(SLOW_PERIOD/2) slowClk = ~slowClk;

  xdom_reg_bridge dut (
    .cpuClk, .cpuRstN, .busValid, .busWrite, .busAddr, .busWdata,
    .busReady, .busRdata, .slowClk, .slowRstN
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge cpuClk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge cpuClk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [3:0] a, output logic [31:0] d);
    @(negedge cpuClk);
    busValid = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busValid = 0;
  endtask

  task automatic waitIdle(input string req);
    logic [31:0] s;
    int n = 0;
    do begin
      busRd(4'h0, s);
      n++;
    end while (s != 0 && n < 400);
    check(req, 32'(n <= MAX_POLL), 32'd1);
  endtask

  function automatic logic [31:0] expRead(input int idx);
    return model[idx];
  endfunction

  task automatic xfer(input logic [7:0] dir, input int idx, input logic [31:0] d);
    busWr(4'h4, {24'h0, dir});
    busWr(4'h8, 32'(idx << 2));
    busWr(4'hC, d);
    busWr(4'h0, 32'h1);
    waitIdle("R9");
    if (dir == 8'hF1) model[idx] = d;
  endtask

  initial begin
    logic [31:0] r;
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    void'($urandom(32'h5EED));
    #(CPU_PERIOD*5) cpuRstN = 1;
    #(SLOW_PERIOD*3) slowRstN = 1;
    repeat (3) @(posedge cpuClk);

    // R1: reset state
    busRd(4'h0, r); check("R1 ctrl", r, 0);
    busRd(4'h4, r); check("R1 dir", r, 0);
    busRd(4'h8, r); check("R1 addr", r, 0);
    busRd(4'hC, r); check("R1 data", r, 0);

    // R2: address field zero-extended, misaligned access ignored
    busWr(4'h8, 32'hFFFF_FFFF);
    busRd(4'h8, r); check("R2 addr width", r, 32'h0000_00FF);
    busWr(4'h1, 32'h1);
    busRd(4'h0, r); check("R2 misaligned launch", r, 0);
    busRd(4'h9, r); check("R2 misaligned read", r, 0);

    // R3: bit0 clear does not launch; launch raises status
    busWr(4'h0, 32'h2);
    busRd(4'h0, r); check("R3 no launch", r, 0);
    busWr(4'h4, 32'hF1); busWr(4'h8, 32'h14); busWr(4'hC, 32'hCAFE_0005);
    busWr(4'h0, 32'h1);
    busRd(4'h0, r); check("R3 busy", r, 1);
    // R7: launch while busy ignored
    busWr(4'h0, 32'h1);
    busRd(4'h0, r); check("R7 still busy", r, 1);
    // R8: field writes while busy ignored
    busWr(4'h8, 32'h30); busWr(4'hC, 32'h1111_2222); busWr(4'h4, 32'h00);
    waitIdle("R9");
    model[5] = 32'hCAFE_0005;
    busRd(4'h0, r); check("R3 idle", r, 0);
    busRd(4'h8, r); check("R8 addr held", r, 32'h14);
    busRd(4'hC, r); check("R8 data held", r, 32'hCAFE_0005);
    busRd(4'h4, r); check("R8 dir held", r, 32'hF1);
    xfer(8'h00, 12, 32'h0);
    busRd(4'hC, r); check("R8 word12 untouched", r, expRead(12));

    // R4/R5: write then read back
    xfer(8'h00, 5, 32'h0);
    busRd(4'hC, r); check("R4 readback", r, expRead(5));
    xfer(8'hF1, 63, 32'hDEAD_BEEF);
    busRd(4'hC, r); check("R5 data kept", r, 32'hDEAD_BEEF);
    xfer(8'h00, 0, 32'h0);
    busRd(4'hC, r); check("R4 word0", r, expRead(0));
    xfer(8'h00, 63, 32'h0);
    busRd(4'hC, r); check("R4 word63", r, expRead(63));

    // R6: other codes are no-ops
    xfer(8'h0F, 63, 32'h1234_5678);
    busRd(4'hC, r); check("R6 data kept", r, 32'h1234_5678);
    xfer(8'h00, 63, 32'h0);
    busRd(4'hC, r); check("R6 word untouched", r, expRead(63));

    // random mix checked against the model
    for (int k = 0; k < 40; k++) begin
      int idx = int'($urandom_range(WORDS-1));
      if ($urandom_range(1) == 1) begin
        logic [31:0] d = $urandom();
        xfer(8'hF1, idx, d);
        busRd(4'hC, r); check("R5 random", r, d);
      end else begin
        xfer(8'h00, idx, 32'hFFFF_FFFF);
        busRd(4'hC, r); check("R4 random", r, expRead(idx));
      end
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #(CPU_PERIOD*150000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule